// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a 128-bit protection register made of two 64-bit halves and a small lock word. All three are reached as 16-bit words at nine consecutive word offsets, starting at a base offset. The half at the lower offsets is a unique identifier that is fixed at build time through a parameter and can never be written. The upper half is user data with a one-time-programmable behaviour. Its erased value is all ones, and each program operation can only turn ones into zeros. The lock word carries two active protection bits. Clearing the user-lock bit freezes the user data and the whole lock word. Clearing the security-lock bit raises an output flag that the surrounding block-lock logic uses to protect security block 0 for good.

Reads return the addressed word one clock after the offset is presented. A program operation starts with a one-cycle request. The block then reports busy for a fixed number of clock cycles, which a parameter sets. It then returns a single done pulse, with an error flag valid in that same cycle. The rules are checked against the state at the moment the request is accepted. A rejected request leaves every stored bit unchanged. A program operation cannot be paused or queued behind another one. The model has no non-volatile retention: reset returns every cell to its erased value.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset `busy`, `done`, `err` and `sec_blk_lock` are 0, every user word reads FFFFh and the lock word reads 0006h.
- R2: `rd_data` shows, one clock after `rd_offset` is sampled, the word at that offset. Base+1..base+4 return identifier bits [15:0], [31:16], [47:32], [63:48] in that order. Base+5..base+8 return user words 0..3. Any offset outside base..base+8 returns 0000h.
- R3: The lock word at the base offset reads bit 1 = user-lock bit and bit 2 = security-lock bit (1 = open, 0 = locked), and reads 0 in bit 0 and bits 15:3.
- R4: A successful program of a user word stores the bitwise AND of the old word and `pgm_data`, so bits can only go from 1 to 0.
- R5: A request accepted at a clock edge holds `busy` high for exactly PGM_CYCLES cycles. In the cycle `busy` falls, `done` is high for one cycle. `err` is only ever high together with `done`.
- R6: A program aimed at an identifier offset or at any offset outside base..base+8 ends with `err` = 1 and changes nothing.
- R7: Once the user-lock bit is 0, a program of any user word ends with `err` = 1 and the word is unchanged.
- R8: Once the user-lock bit is 0, a program of the lock word ends with `err` = 1 and the security-lock bit no longer changes.
- R9: A successful program that clears bit 2 of the lock word sets `sec_blk_lock` to 1, and it stays 1 until reset.
- R10: A `pgm_start` pulse while `busy` is high is ignored: no second operation runs and its data is never stored.
- R11: Writing bit 0 or bits 15:3 of the lock word has no effect, and those bits still read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_offset | input | 8 | Word offset to read |
| rd_data | output | 16 | Registered read data |
| pgm_start | input | 1 | One-cycle program request, taken when not busy |
| pgm_offset | input | 8 | Word offset to program |
| pgm_data | input | 16 | Value ANDed into the target word |
| busy | output | 1 | Program operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Rejected-operation flag, valid with done |
| sec_blk_lock | output | 1 | Permanent protection flag for security block 0 |

## Verification
The bench builds the block with PGM_CYCLES = 5, which keeps each program operation short. This allows a long sequence of operations that depend on each other to run back to back, and the busy window is still long enough to inject a second request inside it. The identifier parameter is 64'h1122_3344_5566_7788, so each of its four words is distinct. A word-order or slice error then shows up as a wrong value instead of a match by chance. The base offset stays at its default of 80h, so the probes at 7Fh and 89h exercise both edges of the decoded range.

// File: rtl/otp_pkg.sv
// Shared constants and types for the protection register controller.
// Assumes 16-bit words and a user segment the same size as the identifier.
package otp_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned OFS_W     = 8;
    localparam int unsigned SEG_WORDS = 4;
    localparam int unsigned SEG_BITS  = WORD_W * SEG_WORDS;
    localparam int unsigned IDX_W     = $clog2(SEG_WORDS);

    // Which area an offset falls into
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_LOCK = 2'd1,
        RG_UID  = 2'd2,
        RG_USER = 2'd3
    } otp_region_e;

    // Program request captured at acceptance
    typedef struct packed {
        otp_region_e         rg;
        logic [IDX_W-1:0]    idx;
        logic [WORD_W-1:0]   data;
        logic                rej;
    } otp_req_t;
endpackage

// File: rtl/otp_decode.sv
// Offset decoder: maps a word offset to a region and a word index.
// Assumes the lock word sits at BASE_OFS, followed by the identifier words
// and then the user words, each segment SEG_WORDS long.
module otp_decode
    import otp_pkg::*;
#(
    parameter logic [OFS_W-1:0] BASE_OFS = 8'h80
) (
    input  logic [OFS_W-1:0] offset,
    output otp_region_e      region,
    output logic [IDX_W-1:0] idx
);
    localparam logic [OFS_W-1:0] UID_FIRST  = OFS_W'(1);
    localparam logic [OFS_W-1:0] UID_LAST   = OFS_W'(SEG_WORDS);
    localparam logic [OFS_W-1:0] USER_FIRST = OFS_W'(SEG_WORDS + 1);
    localparam logic [OFS_W-1:0] USER_LAST  = OFS_W'(2 * SEG_WORDS);

    logic [OFS_W-1:0] rel;

    // Classify the offset relative to the base
    always_comb begin
        rel    = offset - BASE_OFS;
        region = RG_NONE;
        idx    = '0;
        if (rel == '0) begin
            region = RG_LOCK;
        end else if (rel >= UID_FIRST && rel <= UID_LAST) begin
            region = RG_UID;
            idx    = IDX_W'(rel - UID_FIRST);
        end else if (rel >= USER_FIRST && rel <= USER_LAST) begin
            region = RG_USER;
            idx    = IDX_W'(rel - USER_FIRST);
        end
    end
endmodule

// File: rtl/otp_rules.sv
// Protection rule check: decides whether a program request must be rejected.
// Assumes lock bits are stored active-low (1 = open, 0 = locked).
module otp_rules
    import otp_pkg::*;
(
    input  otp_region_e region,
    input  logic        user_open,
    output logic        reject
);
    // Identifier and unmapped offsets always fail; user words and the
    // lock word fail once the user-lock bit has been cleared
    always_comb begin
        unique case (region)
            RG_LOCK: reject = !user_open;
            RG_USER: reject = !user_open;
            default: reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/otp_seq.sv
// Program sequencer: accepts a request when idle, holds busy for PGM_CYCLES
// cycles, flags the final busy cycle for commit and pulses done after it.
// Assumes PGM_CYCLES >= 1; requests while busy are dropped.
module otp_seq #(
    parameter int unsigned PGM_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(PGM_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign accept = start && !busy;
    assign last   = busy && (cnt == '0);

    // Run the busy window and produce the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(PGM_CYCLES - 1);
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt  <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/otp_store.sv
// Storage for the user words and lock bits, with the read multiplexer.
// Assumes reset stands in for the erased state (no retention is modelled)
// and that commit is only raised for an accepted, non-rejected request.
module otp_store
    import otp_pkg::*;
#(
    parameter logic [SEG_BITS-1:0] UID_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  otp_region_e       wr_region,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  otp_region_e       rd_region,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              user_open,
    output logic              sec_open
);
    logic [WORD_W-1:0] user_mem [SEG_WORDS];

    generate
        for (genvar w = 0; w < SEG_WORDS; w++) begin : g_user
            // One user word: erased to all ones, programmed by AND only
            always_ff @(posedge clk) begin
                if (!rst_n)
                    user_mem[w] <= '1;
                else if (commit && wr_region == RG_USER && wr_idx == IDX_W'(w))
                    user_mem[w] <= user_mem[w] & wr_data;
            end
        end
    endgenerate

    // Lock bits: erased open, cleared by programming bits 1 and 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_open <= 1'b1;
            sec_open  <= 1'b1;
        end else if (commit && wr_region == RG_LOCK) begin
            user_open <= user_open & wr_data[1];
            sec_open  <= sec_open  & wr_data[2];
        end
    end

    // Select the word seen by the read port
    always_comb begin
        unique case (rd_region)
            RG_LOCK: rd_word = {{(WORD_W-3){1'b0}}, sec_open, user_open, 1'b0};
            RG_UID:  rd_word = UID_VALUE[rd_idx*WORD_W +: WORD_W];
            RG_USER: rd_word = user_mem[rd_idx];
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/otp_prot_reg.sv
// Protection register controller top: registered read port, one-time
// program port with protection rules, and the security block 0 flag.
// Assumes requests are single-cycle pulses; the rules are evaluated
// against the state at acceptance, which cannot change while busy.
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter logic [63:0]     UID_VALUE  = 64'h0123_4567_89AB_CDEF,
    parameter int unsigned     PGM_CYCLES = 8,
    parameter logic [7:0]      BASE_OFS   = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rd_offset,
    output logic [15:0] rd_data,
    input  logic        pgm_start,
    input  logic [7:0]  pgm_offset,
    input  logic [15:0] pgm_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        sec_blk_lock
);
    otp_region_e      rd_rg, pg_rg;
    logic [IDX_W-1:0] rd_ix, pg_ix;
    logic             user_open, sec_open, reject;
    logic             accept, last;
    logic [WORD_W-1:0] rd_word;
    otp_req_t         req_q;

    otp_decode #(.BASE_OFS(BASE_OFS)) u_rd_dec (
        .offset(rd_offset), .region(rd_rg), .idx(rd_ix)
    );

    otp_decode #(.BASE_OFS(BASE_OFS)) u_pg_dec (
        .offset(pgm_offset), .region(pg_rg), .idx(pg_ix)
    );

    otp_rules u_rules (
        .region(pg_rg), .user_open(user_open), .reject(reject)
    );

    otp_seq #(.PGM_CYCLES(PGM_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(pgm_start),
        .accept(accept), .last(last), .busy(busy), .done(done)
    );

    otp_store #(.UID_VALUE(UID_VALUE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit(last && !req_q.rej),
        .wr_region(req_q.rg), .wr_idx(req_q.idx), .wr_data(req_q.data),
        .rd_region(rd_rg), .rd_idx(rd_ix), .rd_word(rd_word),
        .user_open(user_open), .sec_open(sec_open)
    );

    // Capture the request and its verdict when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= '{rg: RG_NONE, idx: '0, data: '0, rej: 1'b0};
        else if (accept)
            req_q <= '{rg: pg_rg, idx: pg_ix, data: pgm_data, rej: reject};
    end

    // Report the verdict alongside the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= last && req_q.rej;
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_word;
    end

    assign sec_blk_lock = !sec_open;
endmodule

// File: rtl/otp_prot_reg_chk.sv
// Assertion checker for otp_prot_reg, attached with bind below.
module otp_prot_reg_chk #(
    parameter logic [7:0] BASE_OFS = 8'h80
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  rd_offset,
    input logic [15:0] rd_data,
    input logic        pgm_start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        sec_blk_lock
);
    logic [7:0] ofs_d;
    logic       vld;

    // Remember the previous read offset and whether it is post-reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_d <= '0;
            vld   <= 1'b0;
        end else begin
            ofs_d <= rd_offset;
            vld   <= 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pgm_start)); // R10
    AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sec_blk_lock |=> sec_blk_lock); // R9
    AST_SEC_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_blk_lock) |-> (done && !err)); // R9
    AST_LOCK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ofs_d == BASE_OFS) |-> (rd_data[0] == 1'b0 && rd_data[15:3] == '0)); // R3
endmodule

bind otp_prot_reg otp_prot_reg_chk #(.BASE_OFS(BASE_OFS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_offset(rd_offset), .rd_data(rd_data),
    .pgm_start(pgm_start), .busy(busy), .done(done), .err(err),
    .sec_blk_lock(sec_blk_lock)
);

// File: tb/otp_prot_reg_test.sv
module otp_prot_reg_test;
    localparam int unsigned P   = 5;
    localparam logic [63:0] UID = 64'h1122_3344_5566_7788;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_offset = 8'h00;
    logic [15:0] rd_data;
    logic        pgm_start = 1'b0;
    logic [7:0]  pgm_offset = 8'h00;
    logic [15:0] pgm_data = 16'h0000;
    logic        busy, done, err, sec_blk_lock;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    otp_prot_reg #(.UID_VALUE(UID), .PGM_CYCLES(P), .BASE_OFS(8'h80)) uut (
        .clk(clk), .rst_n(rst_n), .rd_offset(rd_offset), .rd_data(rd_data),
        .pgm_start(pgm_start), .pgm_offset(pgm_offset), .pgm_data(pgm_data),
        .busy(busy), .done(done), .err(err), .sec_blk_lock(sec_blk_lock)
    );

    // Vector: {tag[45:42], is_pgm[41], ofs[40:33], data[32:17], exp_rd[16:1], exp_err[0]}
    localparam int NV = 24;
    localparam logic [45:0] VEC [NV] = '{
        {4'd3,  1'b0, 8'h80, 16'h0000, 16'h0006, 1'b0}, // R3 lock word
        {4'd2,  1'b0, 8'h81, 16'h0000, 16'h7788, 1'b0}, // R2 uid word 0
        {4'd2,  1'b0, 8'h83, 16'h0000, 16'h3344, 1'b0}, // R2 uid word 2
        {4'd2,  1'b0, 8'h84, 16'h0000, 16'h1122, 1'b0}, // R2 uid word 3
        {4'd1,  1'b0, 8'h85, 16'h0000, 16'hFFFF, 1'b0}, // R1 erased user
        {4'd2,  1'b0, 8'h7F, 16'h0000, 16'h0000, 1'b0}, // R2 below range
        {4'd2,  1'b0, 8'h89, 16'h0000, 16'h0000, 1'b0}, // R2 above range
        {4'd4,  1'b1, 8'h85, 16'hF0F0, 16'h0000, 1'b0}, // R4 program
        {4'd4,  1'b0, 8'h85, 16'h0000, 16'hF0F0, 1'b0},
        {4'd4,  1'b1, 8'h85, 16'h0FFF, 16'h0000, 1'b0}, // R4 AND only
        {4'd4,  1'b0, 8'h85, 16'h0000, 16'h00F0, 1'b0},
        {4'd4,  1'b1, 8'h88, 16'h1234, 16'h0000, 1'b0},
        {4'd4,  1'b0, 8'h88, 16'h0000, 16'h1234, 1'b0},
        {4'd6,  1'b1, 8'h82, 16'h0000, 16'h0000, 1'b1}, // R6 uid write
        {4'd6,  1'b0, 8'h82, 16'h0000, 16'h5566, 1'b0},
        {4'd6,  1'b1, 8'h90, 16'h0000, 16'h0000, 1'b1}, // R6 unmapped
        {4'd11, 1'b1, 8'h80, 16'hFFF6, 16'h0000, 1'b0}, // R11 reserved bits
        {4'd11, 1'b0, 8'h80, 16'h0000, 16'h0006, 1'b0},
        {4'd7,  1'b1, 8'h80, 16'hFFFD, 16'h0000, 1'b0}, // R7 set user lock
        {4'd7,  1'b0, 8'h80, 16'h0000, 16'h0004, 1'b0},
        {4'd7,  1'b1, 8'h86, 16'h0000, 16'h0000, 1'b1}, // R7 locked user
        {4'd7,  1'b0, 8'h86, 16'h0000, 16'hFFFF, 1'b0},
        {4'd8,  1'b1, 8'h80, 16'hFFFB, 16'h0000, 1'b1}, // R8 lock word frozen
        {4'd8,  1'b0, 8'h80, 16'h0000, 16'h0004, 1'b0}
    };

    task automatic chk(input int tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_read(input int tag, input logic [7:0] ofs, input logic [15:0] exp);
        @(negedge clk);
        rd_offset = ofs;
        @(negedge clk);
        chk(tag, $sformatf("read %h", ofs), rd_data, exp);
    endtask

    task automatic do_pgm(input int tag, input logic [7:0] ofs, input logic [15:0] d, input logic exp_err);
        int n = 0;
        @(negedge clk);
        pgm_start = 1'b1; pgm_offset = ofs; pgm_data = d;
        @(negedge clk);
        pgm_start = 1'b0;
        for (int i = 0; i < P + 4 && !done; i++) begin
            if (busy) n++;
            @(negedge clk);
        end
        chk(5, "done seen", 16'(done), 16'd1);
        chk(5, "busy cycles", 16'(n), 16'(P));
        chk(tag, $sformatf("err program %h", ofs), 16'(err), 16'(exp_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, "busy after reset", 16'(busy), 16'd0);
        chk(1, "done after reset", 16'(done), 16'd0);
        chk(1, "err after reset", 16'(err), 16'd0);
        chk(1, "sec_blk_lock after reset", 16'(sec_blk_lock), 16'd0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][41])
                do_pgm(int'(VEC[v][45:42]), VEC[v][40:33], VEC[v][32:17], VEC[v][0]);
            else
                do_read(int'(VEC[v][45:42]), VEC[v][40:33], VEC[v][16:1]);
        end
        chk(7, "sec flag with only user lock", 16'(sec_blk_lock), 16'd0);

        // R1 reset returns erased state
        do_reset();
        do_read(1, 8'h80, 16'h0006);
        do_read(1, 8'h85, 16'hFFFF);
        do_read(1, 8'h88, 16'hFFFF);

        // R9 security lock sets and stays
        do_pgm(9, 8'h80, 16'hFFFB, 1'b0);
        chk(9, "sec_blk_lock set", 16'(sec_blk_lock), 16'd1);
        do_read(9, 8'h80, 16'h0002);
        do_pgm(9, 8'h80, 16'hFFFF, 1'b0);
        chk(9, "sec_blk_lock held", 16'(sec_blk_lock), 16'd1);
        do_read(9, 8'h80, 16'h0002);

        // R10 request during busy is dropped
        @(negedge clk);
        pgm_start = 1'b1; pgm_offset = 8'h87; pgm_data = 16'hAAAA;
        @(negedge clk);
        pgm_offset = 8'h87; pgm_data = 16'h5555;
        @(negedge clk);
        pgm_start = 1'b0;
        for (int i = 0; i < P + 4 && !done; i++) @(negedge clk);
        chk(10, "first op done", 16'(done), 16'd1);
        begin
            int extra = 0;
            for (int i = 0; i < P + 3; i++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk(10, "no second operation", 16'(extra), 16'd0);
        end
        do_read(10, 8'h87, 16'hAAAA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule